// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is a half-duplex synchronous serial port meant for widening parallel I/O through external shift-register logic. It moves one byte at a time, least-significant bit first, over one bidirectional data pin. A second pin only ever outputs the shift clock. The block runs from the oscillator clock. An internal phase counter divides each machine cycle into twelve slots, and one bit moves per machine cycle.

A byte write starts a transmit. Each bit is presented on the data pin at the start of a machine cycle and held there for the whole cycle. The shift clock falls at slot 4 and rises again at slot 10 of every active cycle. A receive starts when the receive-enable input is high and the receive-done flag is clear. The port then clocks out eight pulses and samples the data pin on each rising edge of the shift clock. When the receive finishes, the assembled byte goes to the read buffer. Software clears the two done flags through dedicated clear strobes. Byte writes that arrive while a transfer is pending or running are dropped.

Top module: `sio_shift_port`

## Requirements
- R1: During and right after synchronous reset, shift_clk is 1, sd_oe is 0, both done flags are 0 and rd_data is 0.
- R2: After a byte write in idle, the port drives sd_oe=1 and puts bit 0 then bits 1..7 on sd_out. Each bit changes only while shift_clk is high and is held for one machine cycle (12 clocks).
- R3: In every active machine cycle, shift_clk falls 4 clocks after the bit boundary and stays low for exactly 6 clocks. A bit lasts 12 clocks.
- R4: tx_done becomes 1 two clocks after the eighth rising edge of shift_clk. sd_oe returns to 0 on the same edge that sets tx_done.
- R5: A receive starts only when rx_en=1 and rx_done=0. Its first shift_clk fall comes within 20 clocks of those conditions holding. With rx_en=0 or rx_done=1 no shift_clk pulse appears.
- R6: A receive samples sd_in on each rising edge of shift_clk, with the first sample as bit 0. Two clocks after the eighth rise, rd_data holds the byte and rx_done is 1.
- R7: sd_oe stays 0 during a receive and while idle, and shift_clk is high whenever no transfer runs.
- R8: A byte write while a transfer is pending or running has no effect on the bits sent, and it starts no later transfer.
- R9: tx_done_clr and rx_done_clr clear their flag on the next clock. Without a clear, a flag holds its value, and a flag set takes priority over a clear in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe (starts a transmit when idle) |
| wr_data | input | 8 | Byte to transmit |
| rd_data | output | 8 | Last received byte |
| rx_en | input | 1 | Receive enable level |
| tx_done | output | 1 | Transmit-done flag |
| rx_done | output | 1 | Receive-done flag |
| tx_done_clr | input | 1 | Clears tx_done |
| rx_done_clr | input | 1 | Clears rx_done |
| sd_in | input | 1 | Data pin input value |
| sd_out | output | 1 | Data pin output value |
| sd_oe | output | 1 | Data pin output enable |
| shift_clk | output | 1 | Shift clock output |

## Verification
A phase counter that is out of step shows up within one machine cycle as a low pulse of the wrong length, or as a data change while shift_clk is low. A bit counter or shift register that goes wrong shows at the ports as a wrong byte, because both the transmitted bits and rd_data are compared bit for bit. If the counter is off by one, the done flag arrives a whole machine cycle early or late, and the two-clock spacing after the last rising edge catches it. A corrupted sequencer state shows as shift_clk pulses while the port should be blocked, or as sd_oe high during a receive.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TX_WAIT,
    ST_TX_RUN,
    ST_RX_WAIT,
    ST_RX_RUN
  } sio_state_e;
endpackage

// File: rtl/sio_phase.sv
module sio_phase #(
  parameter int MC_LEN    = 12,
  parameter int FALL_SLOT = 4,
  parameter int RISE_SLOT = 10
) (
  input  logic clk,
  input  logic rst,
  output logic mc_last,
  output logic fall_stb,
  output logic rise_stb
);
  localparam int PW = $clog2(MC_LEN);

  logic [PW-1:0] ph_q;

  always_ff @(posedge clk) begin
    if (rst) ph_q <= '0;
    else if (ph_q == PW'(MC_LEN-1)) ph_q <= '0;
    else ph_q <= ph_q + 1'b1;
  end

  // strobes one clock before the slot so the registered clock lands on the slot
  always_comb begin
    mc_last  = (ph_q == PW'(MC_LEN-1));
    fall_stb = (ph_q == PW'(FALL_SLOT-1));
    rise_stb = (ph_q == PW'(RISE_SLOT-1));
  end
endmodule

// File: rtl/sio_seq.sv
module sio_seq
  import sio_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_req,
  input  logic rx_req,
  input  logic mc_last,
  input  logic fall_stb,
  input  logic rise_stb,
  output logic load_tx,
  output logic tx_first,
  output logic tx_next,
  output logic sample,
  output logic tx_fin,
  output logic rx_fin,
  output logic sclk,
  output logic oe
);
  localparam int CW = $clog2(DW);

  sio_state_e    st_q;
  logic [CW-1:0] cnt_q;
  logic          last_bit;
  logic          running;

  always_comb begin
    last_bit = (cnt_q == CW'(DW-1));
    running  = (st_q == ST_TX_RUN) || (st_q == ST_RX_RUN);
    load_tx  = (st_q == ST_IDLE) && wr_req;
    tx_first = (st_q == ST_TX_WAIT) && mc_last;
    tx_next  = (st_q == ST_TX_RUN) && mc_last && !last_bit;
    tx_fin   = (st_q == ST_TX_RUN) && mc_last && last_bit;
    rx_fin   = (st_q == ST_RX_RUN) && mc_last && last_bit;
    sample   = (st_q == ST_RX_RUN) && rise_stb;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (wr_req) st_q <= ST_TX_WAIT;
          else if (rx_req) st_q <= ST_RX_WAIT;
        end
        ST_TX_WAIT: if (mc_last) begin
          st_q  <= ST_TX_RUN;
          cnt_q <= '0;
        end
        ST_RX_WAIT: if (mc_last) begin
          st_q  <= ST_RX_RUN;
          cnt_q <= '0;
        end
        ST_TX_RUN, ST_RX_RUN: if (mc_last) begin
          if (last_bit) st_q <= ST_IDLE;
          else cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk <= 1'b1;
      oe   <= 1'b0;
    end else begin
      if (running && fall_stb) sclk <= 1'b0;
      else if (rise_stb) sclk <= 1'b1;
      if (tx_first) oe <= 1'b1;
      else if (tx_fin) oe <= 1'b0;
    end
  end
endmodule

// File: rtl/sio_shift.sv
module sio_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_tx,
  input  logic [DW-1:0] load_data,
  input  logic          tx_first,
  input  logic          tx_next,
  input  logic          sample,
  input  logic          rx_fin,
  input  logic          din,
  output logic          dout,
  output logic [DW-1:0] rbuf
);
  logic [DW-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
      dout <= 1'b1;
      rbuf <= '0;
    end else begin
      if (load_tx) sh_q <= load_data;
      else if (tx_next) sh_q <= {1'b0, sh_q[DW-1:1]};
      else if (sample) sh_q <= {din, sh_q[DW-1:1]};

      if (tx_first) dout <= sh_q[0];
      else if (tx_next) dout <= sh_q[1];

      if (rx_fin) rbuf <= sh_q;
    end
  end
endmodule

// File: rtl/sio_shift_port.sv
module sio_shift_port #(
  parameter int DW        = 8,
  parameter int MC_LEN    = 12,
  parameter int FALL_SLOT = 4,
  parameter int RISE_SLOT = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          rx_en,
  output logic          tx_done,
  output logic          rx_done,
  input  logic          tx_done_clr,
  input  logic          rx_done_clr,
  input  logic          sd_in,
  output logic          sd_out,
  output logic          sd_oe,
  output logic          shift_clk
);
  logic mc_last, fall_stb, rise_stb;
  logic load_tx, tx_first, tx_next, sample, tx_fin, rx_fin;

  sio_phase #(.MC_LEN(MC_LEN), .FALL_SLOT(FALL_SLOT), .RISE_SLOT(RISE_SLOT)) u_phase (
    .clk(clk), .rst(rst), .mc_last(mc_last), .fall_stb(fall_stb), .rise_stb(rise_stb)
  );

  sio_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst(rst), .wr_req(wr_en), .rx_req(rx_en && !rx_done),
    .mc_last(mc_last), .fall_stb(fall_stb), .rise_stb(rise_stb),
    .load_tx(load_tx), .tx_first(tx_first), .tx_next(tx_next), .sample(sample),
    .tx_fin(tx_fin), .rx_fin(rx_fin), .sclk(shift_clk), .oe(sd_oe)
  );

  sio_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst(rst), .load_tx(load_tx), .load_data(wr_data),
    .tx_first(tx_first), .tx_next(tx_next), .sample(sample), .rx_fin(rx_fin),
    .din(sd_in), .dout(sd_out), .rbuf(rd_data)
  );

  // done flags: a set outranks a clear arriving in the same clock
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_done <= 1'b0;
      rx_done <= 1'b0;
    end else begin
      if (tx_fin) tx_done <= 1'b1;
      else if (tx_done_clr) tx_done <= 1'b0;
      if (rx_fin) rx_done <= 1'b1;
      else if (rx_done_clr) rx_done <= 1'b0;
    end
  end
endmodule

module sio_shift_port_chk (
  input logic clk,
  input logic rst,
  input logic shift_clk,
  input logic sd_oe,
  input logic sd_out,
  input logic tx_done,
  input logic tx_done_clr
);
  logic [7:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) low_cnt <= '0;
    else if (!shift_clk) low_cnt <= low_cnt + 1'b1;
    else low_cnt <= '0;
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (shift_clk && !sd_oe && !tx_done));

  a_r2_hold_bit: assert property (@(posedge clk) disable iff (rst)
    (sd_oe && $past(sd_oe) && !$stable(sd_out)) |-> shift_clk);

  a_r3_low_six: assert property (@(posedge clk) disable iff (rst)
    $rose(shift_clk) |-> (low_cnt == 8'd6));

  a_r4_oe_drop_sets_done: assert property (@(posedge clk) disable iff (rst)
    $fell(sd_oe) |-> tx_done);

  a_r9_tx_clear: assert property (@(posedge clk) disable iff (rst)
    (tx_done_clr && !sd_oe) |=> !tx_done);
endmodule

bind sio_shift_port sio_shift_port_chk u_chk (
  .clk(clk), .rst(rst), .shift_clk(shift_clk), .sd_oe(sd_oe), .sd_out(sd_out),
  .tx_done(tx_done), .tx_done_clr(tx_done_clr)
);

// File: tb/sio_shift_port_tb_top.sv
module sio_shift_port_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic rx_en = 1'b0;
  logic tx_done, rx_done;
  logic tx_done_clr = 1'b0;
  logic rx_done_clr = 1'b0;
  logic sd_in = 1'b0;
  logic sd_out, sd_oe, shift_clk;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int low_len = 0;

  always #2 clk = ~clk;

  sio_shift_port dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .rx_en(rx_en), .tx_done(tx_done), .rx_done(rx_done),
    .tx_done_clr(tx_done_clr), .rx_done_clr(rx_done_clr),
    .sd_in(sd_in), .sd_out(sd_out), .sd_oe(sd_oe), .shift_clk(shift_clk)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // R3: every low pulse of the shift clock is six clocks long
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
    if (!rst) begin
      if (!shift_clk) low_len++;
      else if (low_len != 0) begin
        check(low_len == 6, "R3 low width", low_len, 6);
        low_len = 0;
      end
    end
  end

  // wait for a 1->0 of shift_clk; returns clocks waited, -1 on timeout
  task automatic wait_fall(input int limit, output int waited);
    logic p;
    p = shift_clk;
    waited = -1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (p && !shift_clk) begin waited = i; return; end
      p = shift_clk;
    end
  endtask

  task automatic wait_rise(output int waited);
    waited = -1;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      if (shift_clk) begin waited = i; return; end
    end
  endtask

  task automatic pulse_write(input logic [7:0] d);
    wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    check(shift_clk === 1'b1, "R1 shift_clk", shift_clk, 1);
    check(sd_oe === 1'b0, "R1 sd_oe", sd_oe, 0);
    check(tx_done === 1'b0 && rx_done === 1'b0, "R1 flags", {tx_done, rx_done}, 0);
    check(rd_data === 8'h00, "R1 rd_data", rd_data, 0);
  endtask

  // sends a byte; optional second write while busy must not change anything (R8)
  task automatic t_tx(input logic [7:0] d, input bit poke, input logic [7:0] junk);
    logic [7:0] got;
    int w, r;
    logic prev;
    got = '0;
    pulse_write(d);
    if (poke) pulse_write(junk);
    for (int b = 0; b < 8; b++) begin
      wait_fall(40, w);
      check(w > 0, "R2 fall seen", w, 1);
      check(sd_oe === 1'b1, "R2 sd_oe during tx", sd_oe, 1);
      got[b] = sd_out;
      prev = sd_out;
      wait_rise(r);
      check(r == 6, "R3 rise spacing", r, 6);
      check(sd_out === prev, "R2 bit held while low", sd_out, prev);
    end
    check(got == d, poke ? "R8 bits unchanged by write" : "R2 byte LSB first", got, d);
    check(tx_done === 1'b0, "R4 not yet done", tx_done, 0);
    @(negedge clk);
    check(tx_done === 1'b0, "R4 done after 2 clocks", tx_done, 0);
    @(negedge clk);
    check(tx_done === 1'b1, "R4 tx_done set", tx_done, 1);
    check(sd_oe === 1'b0, "R4 sd_oe released", sd_oe, 0);
    if (poke) begin
      wait_fall(40, w);
      check(w < 0, "R8 no later transfer", w, -1);
    end
    tx_done_clr = 1'b1;
    @(negedge clk);
    tx_done_clr = 1'b0;
    check(tx_done === 1'b0, "R9 tx_done cleared", tx_done, 0);
  endtask

  // external source: new bit after each fall, port samples at the rise
  task automatic t_rx(input logic [7:0] d, input bit poke);
    int w, r;
    rx_en = 1'b1;
    if (rx_done) begin
      rx_done_clr = 1'b1;
      @(negedge clk);
      rx_done_clr = 1'b0;
    end
    for (int b = 0; b < 8; b++) begin
      wait_fall(b == 0 ? 20 : 12, w);
      if (b == 0) check(w > 0 && w <= 20, "R5 start latency", w, 20);
      else check(w == 6, "R3 bit period", w, 6);
      if (b == 1 && poke) wr_data = 8'hff;
      if (b == 1 && poke) wr_en = 1'b1;
      sd_in = d[b];
      check(sd_oe === 1'b0, "R7 no drive during rx", sd_oe, 0);
      wait_rise(r);
      wr_en = 1'b0;
      sd_in = ~d[b];
    end
    rx_en = 1'b0;
    check(rx_done === 1'b0, "R6 not yet done", rx_done, 0);
    @(negedge clk);
    @(negedge clk);
    check(rx_done === 1'b1, "R6 rx_done set", rx_done, 1);
    check(rd_data === d, "R6 received byte", rd_data, d);
    if (poke) begin
      wait_fall(40, w);
      check(w < 0, "R8 write during rx ignored", w, -1);
      check(sd_oe === 1'b0, "R8 no drive after rx", sd_oe, 0);
    end
    check(shift_clk === 1'b1, "R7 idle clock high", shift_clk, 1);
  endtask

  task automatic t_rx_blocked();
    int w;
    rx_en = 1'b1;
    wait_fall(40, w);
    check(w < 0, "R5 blocked by rx_done", w, -1);
    check(rx_done === 1'b1, "R9 rx_done holds", rx_done, 1);
    rx_en = 1'b0;
    rx_done_clr = 1'b1;
    @(negedge clk);
    rx_done_clr = 1'b0;
    check(rx_done === 1'b0, "R9 rx_done cleared", rx_done, 0);
    wait_fall(40, w);
    check(w < 0, "R5 blocked by rx_en low", w, -1);
    check(rd_data === 8'h3c, "R5 rd_data unchanged", rd_data, 8'h3c);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_tx(8'ha5, 1'b0, 8'h00);
    t_tx(8'h01, 1'b1, 8'hfe);
    t_tx(8'h80, 1'b0, 8'h00);
    t_rx(8'h3c, 1'b0);
    t_rx_blocked();
    t_rx(8'hc3, 1'b1);
    t_rx(8'h3c, 1'b0);
    t_rx_blocked();
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule